// File: doc/BRIEF.md
# Raster Timing Generator with Frame Counters

The block generates the horizontal and vertical blanking and sync waveforms for one display pipe. It runs on the pixel clock and tracks the raster position with a horizontal pixel position and a line number. The geometry comes from a set of programmable timing registers. Software writes the timing into a shadow set. The generator runs from an active set, and the shadow set is copied into the active set at the start of vertical blank, so a new mode never takes effect in the middle of a frame.

Three single-cycle event pulses mark the raster: vblank start, vsync start and a frame-start pulse that a control field can delay by up to three lines. Software can read four counters through the register port. A scanline counter steps on the hsync leading edge and trails the line by a fixed amount. A pixel counter runs through the whole frame. A 24-bit frame counter counts vblank starts. A frame timestamp holds the value of a free-running timestamp counter, captured at each vblank start. A pixel-counter read also captures the frame counter, so the two always come from the same moment.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held and directly after it, the position is pixel 0 of line 0 and every sync, blank and event output is low. The active and shadow sets hold the parameter defaults, the scanline counter reads vtotal-1, and the frame count, pixel count and timestamp are 0.
- R2: Each clock, hblank_o shows (pos >= hactive) and hsync_o shows (hsync_start <= pos < hsync_end) for the position before that clock. A line ends on the clock where pos >= htotal-1. A frame ends when a line ends with line >= vtotal-1.
- R3: vblank_o is set at the hsync leading edge (pos == hsync_start) of line vactive-1 and cleared at the hsync leading edge of line vtotal-1.
- R4: The vblank-start pulse ev_vblank_o lasts one clock and follows the hsync leading edge of line vactive-1. On that same edge the frame counter increments, the active set loads and the timestamp is captured.
- R5: vsync_o is set at the hsync leading edge of line vsync_start and cleared at the hsync leading edge of line vsync_end. ev_vsync_o pulses for one clock on the setting edge.
- R6: ev_frame_o pulses for one clock at the start of hblank (pos == hactive) on line vactive+d. Here d is control bits [1:0] (0 to 3).
- R7: The scanline counter changes only at hsync leading edges. After the edge on line v it reads v when control bit 2 is 0, and (v-1) mod vtotal when bit 2 is 1.
- R8: The pixel counter is 0 at the first pixel of line 0 and increments on every clock.
- R9: The frame counter is 24 bits wide, wraps modulo 2^24, adds one per vblank start and reads zero-extended.
- R10: Writes to addresses 0-8 land in the shadow set, and reads of those addresses return the shadow value. The map is 0 hactive, 1 hsync_start, 2 hsync_end, 3 htotal, 4 vactive, 5 vsync_start, 6 vsync_end, 7 vtotal, 8 control. The raster uses the active set only, which loads from the shadow set on the vblank-start edge.
- R11: A read of address 10 (pixel counter) also captures the frame counter. A read of address 11 returns that captured value.
- R12: The timestamp (address 13) increments once per clock from 0 after reset. Address 12 returns the timestamp value present just before the most recent vblank-start edge.
- R13: rd_data_o is registered: it shows the addressed value (9 = scanline) one clock after a cycle with rd_en_i high and holds while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Shadow register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Registered read data |
| hblank_o | output | 1 | Horizontal blank |
| hsync_o | output | 1 | Horizontal sync |
| vblank_o | output | 1 | Vertical blank |
| vsync_o | output | 1 | Vertical sync |
| ev_vblank_o | output | 1 | Vblank-start pulse |
| ev_frame_o | output | 1 | Frame-start pulse |
| ev_vsync_o | output | 1 | Vsync-start pulse |

## Verification
Every waveform output and event pulse shows the state decoded from the raster position one clock earlier. Register reads return data one clock after the strobe. The bench therefore advances a position model on the same rising edge as the design and compares the outputs on the following falling edge. Each timing set in the vector table is followed through its latch edge and two whole frames. The directed tests place a pixel read exactly on the vblank-start edge, which checks the atomic snapshot and the timestamp capture on the cycle they are due.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;
  parameter int HW  = 12;
  parameter int VW  = 12;
  parameter int DW  = 32;
  parameter int AW  = 4;
  parameter int FCW = 24;
  parameter int TSW = 32;
  parameter int PXW = HW + VW;

  typedef struct packed {
    logic [HW-1:0] hact;
    logic [HW-1:0] hss;
    logic [HW-1:0] hse;
    logic [HW-1:0] htot;
    logic [VW-1:0] vact;
    logic [VW-1:0] vss;
    logic [VW-1:0] vse;
    logic [VW-1:0] vtot;
    logic [1:0]    fs_dly;
    logic          lag2;
  } timing_t;

  typedef enum logic [AW-1:0] {
    A_HACT = 4'd0, A_HSS = 4'd1, A_HSE = 4'd2, A_HTOT = 4'd3,
    A_VACT = 4'd4, A_VSS = 4'd5, A_VSE = 4'd6, A_VTOT = 4'd7,
    A_CTRL = 4'd8, A_SCAN = 4'd9, A_PIX = 4'd10, A_FRM = 4'd11,
    A_TSF  = 4'd12, A_TS = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import raster_timing_pkg::*;
#(
  parameter timing_t DEF = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          latch_i,
  output timing_t       shadow_o,
  output timing_t       active_o
);
  timing_t sh_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= DEF;
    end else if (we_i) begin
      case (waddr_i)
        A_HACT: sh_q.hact <= wdata_i[HW-1:0];
        A_HSS:  sh_q.hss  <= wdata_i[HW-1:0];
        A_HSE:  sh_q.hse  <= wdata_i[HW-1:0];
        A_HTOT: sh_q.htot <= wdata_i[HW-1:0];
        A_VACT: sh_q.vact <= wdata_i[VW-1:0];
        A_VSS:  sh_q.vss  <= wdata_i[VW-1:0];
        A_VSE:  sh_q.vse  <= wdata_i[VW-1:0];
        A_VTOT: sh_q.vtot <= wdata_i[VW-1:0];
        A_CTRL: begin
          sh_q.fs_dly <= wdata_i[1:0];
          sh_q.lag2   <= wdata_i[2];
        end
        default: ;
      endcase
    end
  end

  // reset loads the active set directly; otherwise only the vblank latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      act_q <= DEF;
    else if (latch_i) act_q <= sh_q;
  end

  assign shadow_o = sh_q;
  assign active_o = act_q;

  // R10
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(latch_i) |-> $stable(act_q));
endmodule

// File: rtl/rtg_raster.sv
module rtg_raster
  import raster_timing_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  timing_t       act_i,
  output logic [HW-1:0] hpos_o,
  output logic [VW-1:0] vpos_o,
  output logic          hs_hit_o,
  output logic          vbl_hit_o,
  output logic          frame_end_o,
  output logic          hblank_o,
  output logic          hsync_o,
  output logic          vblank_o,
  output logic          vsync_o,
  output logic          ev_vblank_o,
  output logic          ev_frame_o,
  output logic          ev_vsync_o
);
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          line_end, fs_hit, vs_hit;

  assign line_end    = h_q >= act_i.htot - HW'(1);
  assign frame_end_o = line_end && (v_q >= act_i.vtot - VW'(1));
  assign hs_hit_o    = h_q == act_i.hss;
  assign vbl_hit_o   = hs_hit_o && (v_q == act_i.vact - VW'(1));
  assign vs_hit      = hs_hit_o && (v_q == act_i.vss);
  assign fs_hit      = (h_q == act_i.hact) && (v_q == act_i.vact + VW'(act_i.fs_dly));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (line_end) begin
      h_q <= '0;
      v_q <= frame_end_o ? '0 : v_q + VW'(1);
    end else begin
      h_q <= h_q + HW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hblank_o    <= 1'b0;
      hsync_o     <= 1'b0;
      vblank_o    <= 1'b0;
      vsync_o     <= 1'b0;
      ev_vblank_o <= 1'b0;
      ev_frame_o  <= 1'b0;
      ev_vsync_o  <= 1'b0;
    end else begin
      hblank_o    <= h_q >= act_i.hact;
      hsync_o     <= (h_q >= act_i.hss) && (h_q < act_i.hse);
      ev_vblank_o <= vbl_hit_o;
      ev_frame_o  <= fs_hit;
      ev_vsync_o  <= vs_hit;
      // vertical state moves only on the hsync leading edge
      if (vbl_hit_o)                                  vblank_o <= 1'b1;
      else if (hs_hit_o && v_q == act_i.vtot - VW'(1)) vblank_o <= 1'b0;
      if (vs_hit)                                     vsync_o  <= 1'b1;
      else if (hs_hit_o && v_q == act_i.vse)          vsync_o  <= 1'b0;
    end
  end

  assign hpos_o = h_q;
  assign vpos_o = v_q;

  // R4
  vbl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_vblank_o |=> !ev_vblank_o);
  // R5
  vs_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_vsync_o |-> vsync_o);
  // R3
  vblank_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vblank_o) |-> $past(hs_hit_o));
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import raster_timing_pkg::*;
#(
  parameter logic [VW-1:0] SCAN_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  timing_t       act_i,
  input  timing_t       shadow_i,
  input  logic [VW-1:0] vpos_i,
  input  logic          hs_hit_i,
  input  logic          vbl_hit_i,
  input  logic          frame_end_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [VW-1:0]  scan_q, scan_nx, lagv;
  logic [PXW-1:0] pix_q;
  logic [FCW-1:0] frame_q, frame_hold_q;
  logic [TSW-1:0] ts_q, ts_frame_q;
  logic [DW-1:0]  rd_d;

  assign lagv    = VW'(act_i.lag2);
  assign scan_nx = (vpos_i >= lagv) ? vpos_i - lagv : vpos_i + act_i.vtot - lagv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q     <= SCAN_RST;
      pix_q      <= '0;
      frame_q    <= '0;
      ts_q       <= '0;
      ts_frame_q <= '0;
    end else begin
      ts_q  <= ts_q + TSW'(1);
      pix_q <= frame_end_i ? '0 : pix_q + PXW'(1);
      if (hs_hit_i) scan_q <= scan_nx;
      if (vbl_hit_i) begin
        frame_q    <= frame_q + FCW'(1);
        ts_frame_q <= ts_q;
      end
    end
  end

  always_comb begin
    rd_d = '0;
    case (rd_addr_i)
      A_HACT: rd_d = DW'(shadow_i.hact);
      A_HSS:  rd_d = DW'(shadow_i.hss);
      A_HSE:  rd_d = DW'(shadow_i.hse);
      A_HTOT: rd_d = DW'(shadow_i.htot);
      A_VACT: rd_d = DW'(shadow_i.vact);
      A_VSS:  rd_d = DW'(shadow_i.vss);
      A_VSE:  rd_d = DW'(shadow_i.vse);
      A_VTOT: rd_d = DW'(shadow_i.vtot);
      A_CTRL: rd_d = DW'({shadow_i.lag2, shadow_i.fs_dly});
      A_SCAN: rd_d = DW'(scan_q);
      A_PIX:  rd_d = DW'(pix_q);
      A_FRM:  rd_d = DW'(frame_hold_q);
      A_TSF:  rd_d = DW'(ts_frame_q);
      A_TS:   rd_d = DW'(ts_q);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o    <= '0;
      frame_hold_q <= '0;
    end else if (rd_en_i) begin
      rd_data_o <= rd_d;
      if (rd_addr_i == A_PIX) frame_hold_q <= frame_q;
    end
  end

  // R7
  scan_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scan_q) |-> $past(hs_hit_i));
  // R9
  frame_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_q) |-> $past(vbl_hit_i) && (frame_q == $past(frame_q) + FCW'(1)));
  // R12
  ts_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vbl_hit_i) |-> ts_frame_q == ts_q - TSW'(1));
  // R13
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rd_data_o));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_timing_pkg::*;
#(
  parameter int DEF_HACT = 16,
  parameter int DEF_HSS  = 18,
  parameter int DEF_HSE  = 20,
  parameter int DEF_HTOT = 24,
  parameter int DEF_VACT = 6,
  parameter int DEF_VSS  = 7,
  parameter int DEF_VSE  = 8,
  parameter int DEF_VTOT = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_addr_i,
  input  logic [31:0]   wr_data_i,
  input  logic          rd_en_i,
  input  logic [3:0]    rd_addr_i,
  output logic [31:0]   rd_data_o,
  output logic          hblank_o,
  output logic          hsync_o,
  output logic          vblank_o,
  output logic          vsync_o,
  output logic          ev_vblank_o,
  output logic          ev_frame_o,
  output logic          ev_vsync_o
);
  localparam timing_t DEF_T = '{
    hact: HW'(DEF_HACT), hss: HW'(DEF_HSS), hse: HW'(DEF_HSE), htot: HW'(DEF_HTOT),
    vact: VW'(DEF_VACT), vss: VW'(DEF_VSS), vse: VW'(DEF_VSE), vtot: VW'(DEF_VTOT),
    fs_dly: 2'd0, lag2: 1'b0};
  localparam logic [VW-1:0] SCAN_RST = VW'(DEF_VTOT - 1);

  timing_t       shadow, active;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic          hs_hit, vbl_hit, frame_end;

  rtg_regs #(.DEF(DEF_T)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_en_i), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .latch_i(vbl_hit), .shadow_o(shadow), .active_o(active)
  );

  rtg_raster u_raster (
    .clk_i, .rst_ni, .act_i(active),
    .hpos_o(hpos), .vpos_o(vpos),
    .hs_hit_o(hs_hit), .vbl_hit_o(vbl_hit), .frame_end_o(frame_end),
    .hblank_o, .hsync_o, .vblank_o, .vsync_o,
    .ev_vblank_o, .ev_frame_o, .ev_vsync_o
  );

  rtg_counters #(.SCAN_RST(SCAN_RST)) u_cnt (
    .clk_i, .rst_ni, .act_i(active), .shadow_i(shadow),
    .vpos_i(vpos), .hs_hit_i(hs_hit), .vbl_hit_i(vbl_hit), .frame_end_i(frame_end),
    .rd_en_i, .rd_addr_i, .rd_data_o
  );

  logic unused_hpos;
  assign unused_hpos = ^hpos;
endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
  import raster_timing_pkg::*;

  localparam int NCFG = 3;
  // hact hss hse htot vact vss vse vtot dly lag
  localparam int CFG [NCFG][10] = '{
    '{ 8, 10, 12, 14, 4, 5, 7,  9, 3, 1},
    '{20, 21, 25, 28, 5, 6, 8, 12, 1, 0},
    '{12, 13, 14, 16, 3, 4, 5,  8, 2, 1}
  };
  localparam timing_t DEF_T = '{hact: 16, hss: 18, hse: 20, htot: 24,
    vact: 6, vss: 7, vse: 8, vtot: 10, fs_dly: 0, lag2: 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic hblank, hsync, vblank, vsync, ev_vbl, ev_fs, ev_vs;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic chk_on = 1'b0;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.DEF_HACT(16), .DEF_HSS(18), .DEF_HSE(20), .DEF_HTOT(24),
    .DEF_VACT(6), .DEF_VSS(7), .DEF_VSE(8), .DEF_VTOT(10)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .hblank_o(hblank), .hsync_o(hsync), .vblank_o(vblank), .vsync_o(vsync),
    .ev_vblank_o(ev_vbl), .ev_frame_o(ev_fs), .ev_vsync_o(ev_vs));

  // reference raster built from the requirements
  timing_t ms, ma;
  logic [HW-1:0] m_h;
  logic [VW-1:0] m_v, m_scan;
  logic [23:0] m_frame;
  logic [31:0] m_ts, m_tsf, m_pix;
  logic e_hb, e_hs, e_vb, e_vs, e_evb, e_efs, e_evs;
  logic [31:0] e_scan;
  logic m_hs, m_hit, m_lend;

  assign m_hs   = m_h == ma.hss;
  assign m_hit  = m_hs && (m_v == ma.vact - 1);
  assign m_lend = m_h >= ma.htot - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= DEF_T; ma <= DEF_T; m_h <= '0; m_v <= '0; m_scan <= 9;
      m_frame <= '0; m_ts <= '0; m_tsf <= '0; m_pix <= '0;
      {e_hb, e_hs, e_vb, e_vs, e_evb, e_efs, e_evs} <= '0; e_scan <= '0;
    end else begin
      e_hb  <= m_h >= ma.hact;
      e_hs  <= m_h >= ma.hss && m_h < ma.hse;
      e_evb <= m_hit;
      e_evs <= m_hs && m_v == ma.vss;
      e_efs <= m_h == ma.hact && m_v == ma.vact + VW'(ma.fs_dly);
      if (m_hit) e_vb <= 1'b1; else if (m_hs && m_v == ma.vtot - 1) e_vb <= 1'b0;
      if (m_hs && m_v == ma.vss) e_vs <= 1'b1; else if (m_hs && m_v == ma.vse) e_vs <= 1'b0;
      e_scan <= 32'(m_scan);
      if (m_hs) m_scan <= ma.lag2 ? ((m_v == 0) ? ma.vtot - 1 : m_v - 1) : m_v;
      if (m_lend) begin
        m_h <= '0;
        m_v <= (m_v >= ma.vtot - 1) ? '0 : m_v + 1;
      end else m_h <= m_h + 1;
      m_pix <= (m_lend && m_v >= ma.vtot - 1) ? '0 : m_pix + 1;
      m_ts  <= m_ts + 1;
      if (m_hit) begin ma <= ms; m_frame <= m_frame + 1; m_tsf <= m_ts; end
      if (wr_en) case (wr_addr)
        0: ms.hact <= HW'(wr_data); 1: ms.hss <= HW'(wr_data);
        2: ms.hse  <= HW'(wr_data); 3: ms.htot <= HW'(wr_data);
        4: ms.vact <= VW'(wr_data); 5: ms.vss <= VW'(wr_data);
        6: ms.vse  <= VW'(wr_data); 7: ms.vtot <= VW'(wr_data);
        8: begin ms.fs_dly <= wr_data[1:0]; ms.lag2 <= wr_data[2]; end
        default: ;
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("R2 R10 hblank", 32'(hblank), 32'(e_hb));
      check("R2 R10 hsync", 32'(hsync), 32'(e_hs));
      check("R3 vblank", 32'(vblank), 32'(e_vb));
      check("R5 vsync", 32'(vsync), 32'(e_vs));
      check("R5 vsync event", 32'(ev_vs), 32'(e_evs));
      check("R4 vblank event", 32'(ev_vbl), 32'(e_evb));
      check("R6 frame start", 32'(ev_fs), 32'(e_efs));
      check("R7 scanline", rd_data, e_scan);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic rd(input logic [3:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    for (int k = 0; k < n; k++) begin
      logic [23:0] f0 = m_frame;
      while (m_frame == f0) @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] x_pix, x_ts, held;
    logic [23:0] x_frm;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1 outputs in reset", {25'd0, hblank, hsync, vblank, vsync, ev_vbl, ev_fs, ev_vs}, 32'd0);
    check("R1 read data in reset", rd_data, 32'd0);
    rst_n = 1'b1;
    rd(4'd9);  check("R1 R7 scanline after reset", rd_data, 32'd9);
    rd(4'd11); check("R1 frame count after reset", rd_data, 32'd0);
    rd(4'd13); check("R1 R12 timestamp", rd_data, m_ts - 1);
    rd(4'd3);  check("R1 R10 default htotal", rd_data, 32'd24);

    // vector walk: program shadow, follow latch plus two frames
    rd_en = 1'b1; rd_addr = 4'd9;
    @(negedge clk);
    chk_on = 1'b1;
    for (int c = 0; c < NCFG; c++) begin
      for (int r = 0; r < 9; r++) begin
        wr_en = 1'b1; wr_addr = 4'(r);
        wr_data = (r == 8) ? 32'(CFG[c][8] | (CFG[c][9] << 2)) : 32'(CFG[c][r]);
        @(negedge clk);
      end
      wr_en = 1'b0;
      wait_frames(3);
    end
    chk_on = 1'b0; rd_en = 1'b0;
    @(negedge clk);

    rd(4'd0); check("R10 shadow readback", rd_data, 32'(CFG[NCFG-1][0]));
    rd(4'd8); check("R10 control readback", rd_data, 32'(CFG[NCFG-1][8] | (CFG[NCFG-1][9] << 2)));
    held = rd_data;
    @(negedge clk);
    check("R13 read data holds", rd_data, held);

    // R8 pixel counter at the first pixel of the frame
    while (!(m_h == 0 && m_v == 0)) @(negedge clk);
    rd(4'd10); check("R8 pixel zero at frame start", rd_data, 32'd0);
    rd(4'd10); check("R8 pixel steps", rd_data, 32'd1);

    // R11 snapshot taken on the vblank-start edge
    while (!m_hit) @(negedge clk);
    x_pix = m_pix; x_frm = m_frame; x_ts = m_ts;
    rd(4'd10); check("R8 pixel at vblank edge", rd_data, x_pix);
    rd(4'd11); check("R11 snapshot frame", rd_data, 32'(x_frm));
    check("R4 R9 frame advanced", 32'(m_frame), 32'(x_frm) + 1);
    rd(4'd12); check("R12 frame timestamp", rd_data, x_ts);
    rd(4'd10);
    rd(4'd11); check("R9 R4 frame count step", rd_data, 32'(x_frm) + 1);
    finish_run();
  end
endmodule